// File: doc/BRIEF.md
# Add-Immediate Unit with Arithmetic Status

This block is one datapath stage of a 32-bit core. It holds a file of eight 32-bit data registers and a 32-bit arithmetic status word. Each accepted operation names a destination register and a signed 7-bit immediate. The stage sign-extends the immediate to 32 bits, adds it to the current contents of that register, and writes the sum back to the same register. In the same clock edge it updates the zero, negative, carry and overflow flags, the mirror copies of carry and overflow, and a sticky overflow summary bit.

Operations enter on a valid/ready stream. The stage applies no back-pressure: `in_ready` is high whenever reset is low, so a transfer happens on every rising edge where `in_valid` is high outside reset. The result stream has no ready input. Each accepted operation yields exactly one `res_valid` pulse on the following cycle, and a consumer must take it in that cycle. Other stages load registers through a plain load port and read them through a combinational read port. Software-visible status is read and overwritten through a separate status port.

Top module: `addimm_unit`

## Requirements
- R1: On an accepted operation, register `in_idx` is written with its old value plus `in_imm` sign-extended from 7 bits, modulo 2^32. Every other register keeps its value. Immediates from -64 to +63 are supported.
- R2: Status bit 0 (zero) is set after an add exactly when the 32-bit sum is zero.
- R3: Status bit 1 (negative) equals bit 31 of the sum after an add.
- R4: Status bit 12 (carry) is the unsigned carry out of bit 31 of the 32-bit add. Status bit 5 (carry mirror) always takes the same value on an add.
- R5: Status bit 24 (overflow) is set when the add overflows as a signed operation and is cleared otherwise. Status bit 25 (overflow mirror) always takes the same value on an add.
- R6: Status bit 26 (sticky overflow) is set by any overflowing add. It stays set through later adds until a status write changes it.
- R7: A status write (`stat_wr_en`) replaces the whole status word with `stat_wdata` masked to bits 0, 1, 5, 12, 24, 25 and 26. All other status bits always read as zero.
- R8: If a status write and an add occur in the same cycle, the written value wins for the status word, and the register write of the sum still happens.
- R9: A synchronous active-high reset clears all eight registers and the status word, and leaves `res_valid` low.
- R10: `in_ready` is high whenever `rst` is low. An accepted operation gives `res_valid` high on the next cycle, with `res_idx` equal to the destination and `res_data` equal to the new sum. In a cycle that follows no accepted operation, `res_valid` is low.
- R11: A load (`ld_en`) writes `ld_data` to register `ld_idx` and leaves the status word unchanged. If an add targets the same register in the same cycle, the add's sum is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Stage can accept an operation |
| in_idx | input | 3 | Destination and source register index |
| in_imm | input | 7 | Signed immediate |
| res_valid | output | 1 | Result valid, one cycle after acceptance |
| res_idx | output | 3 | Register written by the result |
| res_data | output | 32 | Sum written to the register |
| ld_en | input | 1 | Direct register load enable |
| ld_idx | input | 3 | Register to load |
| ld_data | input | 32 | Load value |
| rd_idx | input | 3 | Read port index |
| rd_data | output | 32 | Contents of register `rd_idx` (combinational) |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wdata | input | 32 | Status word write value |
| stat_rdata | output | 32 | Current status word |

## Verification
The add is driven from four starting points on several registers: zero, all ones, the largest positive value and the most negative value. Zero separates the zero flag from carry, because +0 never carries and a step back to zero does carry. All ones separates carry from overflow, since it wraps without a signed overflow. The two signed extremes, stepped across the sign boundary in both directions, separate overflow and its mirror from the sticky bit, which must outlive the step that no longer overflows. Status writes alone and together with an add, loads that collide with an add, and the extreme immediates -64 and +63 cover the priority rules and the sign extension.

// File: rtl/addimm_pkg.sv
package addimm_pkg;
  localparam int unsigned STAT_W    = 32;
  localparam int unsigned POS_ZERO  = 0;
  localparam int unsigned POS_NEG   = 1;
  localparam int unsigned POS_CMIR  = 5;
  localparam int unsigned POS_CARRY = 12;
  localparam int unsigned POS_OVF   = 24;
  localparam int unsigned POS_OMIR  = 25;
  localparam int unsigned POS_STKY  = 26;

  localparam logic [STAT_W-1:0] STAT_MASK =
    (STAT_W'(1) << POS_ZERO) | (STAT_W'(1) << POS_NEG) |
    (STAT_W'(1) << POS_CMIR) | (STAT_W'(1) << POS_CARRY) |
    (STAT_W'(1) << POS_OVF)  | (STAT_W'(1) << POS_OMIR) |
    (STAT_W'(1) << POS_STKY);

  typedef struct packed {
    logic zero;
    logic neg;
    logic carry;
    logic ovf;
  } alu_flags_t;
endpackage

// File: rtl/addimm_flag_calc.sv
module addimm_flag_calc
  import addimm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 7
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] sum,
  output alu_flags_t        flags
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W:0]   wide;

  always_comb begin
    imm_ext     = {{EXT_W{imm[IMM_W-1]}}, imm};
    wide        = {1'b0, opnd} + {1'b0, imm_ext};
    sum         = wide[DATA_W-1:0];
    flags.zero  = (sum == '0);
    flags.neg   = sum[DATA_W-1];
    flags.carry = wide[DATA_W];
    flags.ovf   = (opnd[DATA_W-1] == imm_ext[DATA_W-1]) &&
                  (sum[DATA_W-1] != opnd[DATA_W-1]);
  end
endmodule

// File: rtl/addimm_regfile.sv
module addimm_regfile #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_we,
  input  logic [IDX_W-1:0]  add_idx,
  input  logic [DATA_W-1:0] add_data,
  input  logic              ld_we,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  rda_idx,
  output logic [DATA_W-1:0] rda_data,
  input  logic [IDX_W-1:0]  rdb_idx,
  output logic [DATA_W-1:0] rdb_data
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (add_we && add_idx == IDX_W'(g))
        regs[g] <= add_data;
      else if (ld_we && ld_idx == IDX_W'(g))
        regs[g] <= ld_data;
    end
  end

  assign rda_data = regs[rda_idx];
  assign rdb_data = regs[rdb_idx];
endmodule

// File: rtl/addimm_status_reg.sv
module addimm_status_reg
  import addimm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              upd_en,
  input  alu_flags_t        flags,
  output logic [STAT_W-1:0] q
);
  logic [STAT_W-1:0] upd_val;

  always_comb begin
    upd_val            = '0;
    upd_val[POS_ZERO]  = flags.zero;
    upd_val[POS_NEG]   = flags.neg;
    upd_val[POS_CARRY] = flags.carry;
    upd_val[POS_CMIR]  = flags.carry;
    upd_val[POS_OVF]   = flags.ovf;
    upd_val[POS_OMIR]  = flags.ovf;
    upd_val[POS_STKY]  = flags.ovf | q[POS_STKY];
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (wr_en)
      q <= wr_data & STAT_MASK;
    else if (upd_en)
      q <= upd_val;
  end
endmodule

// File: rtl/addimm_unit.sv
module addimm_unit
  import addimm_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 7,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_idx,
  output logic [DATA_W-1:0] res_data,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stat_wr_en,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] stat_rdata
);
  logic              fire;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] sum;
  alu_flags_t        flags;

  assign in_ready = ~rst;
  assign fire     = in_valid & in_ready;

  addimm_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .add_we   (fire),
    .add_idx  (in_idx),
    .add_data (sum),
    .ld_we    (ld_en),
    .ld_idx   (ld_idx),
    .ld_data  (ld_data),
    .rda_idx  (in_idx),
    .rda_data (opnd),
    .rdb_idx  (rd_idx),
    .rdb_data (rd_data)
  );

  addimm_flag_calc #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_calc (
    .opnd  (opnd),
    .imm   (in_imm),
    .sum   (sum),
    .flags (flags)
  );

  addimm_status_reg u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (stat_wr_en),
    .wr_data (stat_wdata),
    .upd_en  (fire),
    .flags   (flags),
    .q       (stat_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_idx  <= in_idx;
        res_data <= sum;
      end
    end
  end
endmodule

// File: rtl/addimm_unit_chk.sv
module addimm_unit_chk
  import addimm_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 7,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [IDX_W-1:0]  in_idx,
  input logic              res_valid,
  input logic [IDX_W-1:0]  res_idx,
  input logic [DATA_W-1:0] res_data,
  input logic              stat_wr_en,
  input logic [STAT_W-1:0] stat_rdata
);
  logic add_only;
  assign add_only = in_valid && in_ready && !stat_wr_en;

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (stat_rdata == '0 && !res_valid));

  a_r10_ready_out_of_reset: assert property (@(posedge clk) disable iff (rst)
    in_ready);

  a_r10_result_follows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (res_valid && res_idx == $past(in_idx)));

  a_r10_no_spurious_result: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !res_valid);

  a_r2_zero_flag: assert property (@(posedge clk) disable iff (rst)
    add_only |=> (stat_rdata[POS_ZERO] == (res_data == '0)));

  a_r3_neg_flag: assert property (@(posedge clk) disable iff (rst)
    add_only |=> (stat_rdata[POS_NEG] == res_data[DATA_W-1]));

  a_r4_carry_mirror: assert property (@(posedge clk) disable iff (rst)
    add_only |=> (stat_rdata[POS_CMIR] == stat_rdata[POS_CARRY]));

  a_r5_ovf_mirror: assert property (@(posedge clk) disable iff (rst)
    add_only |=> (stat_rdata[POS_OMIR] == stat_rdata[POS_OVF]));

  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    (!stat_wr_en && stat_rdata[POS_STKY]) |=> stat_rdata[POS_STKY]);

  a_r6_sticky_on_ovf: assert property (@(posedge clk) disable iff (rst)
    (add_only) |=> (!stat_rdata[POS_OVF] || stat_rdata[POS_STKY]));

  a_r7_unused_zero: assert property (@(posedge clk) disable iff (rst)
    ((stat_rdata & ~STAT_MASK) == '0));
endmodule

bind addimm_unit addimm_unit_chk #(
  .NREG(NREG), .DATA_W(DATA_W), .IMM_W(IMM_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_idx     (in_idx),
  .res_valid  (res_valid),
  .res_idx    (res_idx),
  .res_data   (res_data),
  .stat_wr_en (stat_wr_en),
  .stat_rdata (stat_rdata)
);

// File: tb/addimm_unit_tb_top.sv
module addimm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_idx = '0;
  logic [6:0]  in_imm = '0;
  logic        res_valid;
  logic [2:0]  res_idx;
  logic [31:0] res_data;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        stat_wr_en = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic [31:0] stat_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [31:0] F_Z  = 32'h0000_0001;
  localparam logic [31:0] F_N  = 32'h0000_0002;
  localparam logic [31:0] F_CM = 32'h0000_0020;
  localparam logic [31:0] F_C  = 32'h0000_1000;
  localparam logic [31:0] F_V  = 32'h0100_0000;
  localparam logic [31:0] F_VM = 32'h0200_0000;
  localparam logic [31:0] F_VS = 32'h0400_0000;
  localparam logic [31:0] MASK = F_Z | F_N | F_CM | F_C | F_V | F_VM | F_VS;

  typedef struct {
    logic [2:0]  idx;
    logic [31:0] data;
    logic [31:0] stat;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] m_reg [8];
  logic [31:0] m_stat;

  always #4 clk = ~clk;

  addimm_unit dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx), .in_imm(in_imm),
    .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .stat_wr_en(stat_wr_en), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference: new status for an add, independent of the design's adder.
  function automatic logic [31:0] ref_stat(input logic [31:0] a, input int imm,
                                           input logic [31:0] old);
    longint su, ss;
    logic [31:0] s, r;
    su = longint'(a) + ((imm < 0) ? (longint'(64'h1_0000_0000) + imm) : imm);
    ss = longint'($signed(a)) + imm;
    s  = su[31:0];
    r  = '0;
    if (s == 0) r |= F_Z;
    if (s[31]) r |= F_N;
    if (su >= 64'sh1_0000_0000) r |= F_C | F_CM;
    if (ss > 64'sh7FFF_FFFF || ss < -64'sh8000_0000) r |= F_V | F_VM | F_VS;
    if (old & F_VS) r |= F_VS;
    return r;
  endfunction

  // Driver: one add, optionally with a simultaneous status write / load.
  task automatic do_add(input int idx, input int imm,
                        input bit sw = 0, input logic [31:0] swv = '0,
                        input bit ld = 0, input logic [31:0] ldv = '0);
    exp_t e;
    logic [31:0] s;
    @(negedge clk);
    s = m_reg[idx] + 32'(imm);
    e.idx  = 3'(idx);
    e.data = s;
    m_stat = sw ? (swv & MASK) : ref_stat(m_reg[idx], imm, m_stat);
    e.stat = m_stat;
    m_reg[idx] = s;
    sb_q.push_back(e);
    in_valid   = 1'b1;
    in_idx     = 3'(idx);
    in_imm     = 7'(imm);
    stat_wr_en = sw;
    stat_wdata = swv;
    ld_en      = ld;
    ld_idx     = 3'(idx);
    ld_data    = ldv;
    @(negedge clk);
    in_valid   = 1'b0;
    stat_wr_en = 1'b0;
    ld_en      = 1'b0;
  endtask

  task automatic do_load(input int idx, input logic [31:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 3'(idx); ld_data = v;
    m_reg[idx] = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic do_swrite(input logic [31:0] v);
    @(negedge clk);
    stat_wr_en = 1'b1; stat_wdata = v;
    m_stat = v & MASK;
    @(negedge clk);
    stat_wr_en = 1'b0;
  endtask

  task automatic check_reg(input string req, input int idx, input logic [31:0] exp);
    rd_idx = 3'(idx);
    #1;
    check(req, $sformatf("reg %0d", idx), rd_data, exp);
  endtask

  task automatic check_all_regs(input string req);
    for (int i = 0; i < 8; i++) check_reg(req, i, m_reg[i]);
  endtask

  // Monitor: pop expected items as results appear.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && res_valid) begin
        if (sb_q.size() == 0) begin
          check("R10", "unexpected result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check("R10", "res_idx", 32'(res_idx), 32'(e.idx));
          check("R1", "res_data", res_data, e.data);
          check("R2-flags", "status", stat_rdata, e.stat);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_stat = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    ld_en = 1'b1; ld_idx = 3'd2; ld_data = 32'hDEAD_BEEF;
    @(negedge clk);
    ld_en = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R9", "status after reset", stat_rdata, 32'h0);
    check("R9", "res_valid after reset", 32'(res_valid), 32'h0);
    check("R10", "in_ready", 32'(in_ready), 32'h1);
    check_all_regs("R9");

    // R2/R4 around zero on register 0
    do_add(0, 0);
    do_add(0, 1);
    do_add(0, -1);
    do_add(0, -1);
    do_add(0, 1);
    @(negedge clk);
    check("R4", "zero after -1,+1", stat_rdata, F_Z | F_C | F_CM);
    check_all_regs("R1");

    // R3/R4 from all ones on register 3, immediate 3
    do_load(3, 32'hFFFF_FFFF);
    do_add(3, 3);
    do_add(3, 0);
    do_add(3, -3);
    @(negedge clk);
    check("R3", "all ones minus", stat_rdata, F_N);
    check_all_regs("R1");

    // R5/R6 from max positive on register 5
    do_swrite(32'h0);
    do_load(5, 32'h7FFF_FFFF);
    do_add(5, 5);
    do_add(5, -5);
    @(negedge clk);
    check("R5", "back across boundary", stat_rdata, F_C | F_CM | F_V | F_VM | F_VS);
    do_add(5, -5);
    @(negedge clk);
    check("R6", "sticky stays", stat_rdata, F_C | F_CM | F_VS);

    // R5/R6 from most negative on register 7, immediate 7
    do_swrite(32'h0);
    check("R7", "write zero clears", stat_rdata, 32'h0);
    do_load(7, 32'h8000_0000);
    do_add(7, -7);
    @(negedge clk);
    check("R5", "min minus 7", stat_rdata, 32'h0700_1020);
    do_add(7, 7);
    @(negedge clk);
    check("R5", "returns to min, negative", stat_rdata, F_N | F_V | F_VM | F_VS);
    do_add(7, 7);
    @(negedge clk);
    check("R6", "sticky after no ovf", stat_rdata, 32'h0400_0002);
    check_reg("R1", 7, 32'h8000_0007);

    // R1 extreme immediates
    do_load(4, 32'h0000_1000);
    do_add(4, -64);
    do_add(4, 63);
    @(negedge clk);
    check_reg("R1", 4, 32'h0000_0FFF);

    // R7: status write masks unused bits
    do_swrite(32'hFFFF_FFFF);
    check("R7", "masked write", stat_rdata, MASK);

    // R8: status write and add together
    do_add(1, 2, 1'b1, 32'h0000_0003);
    @(negedge clk);
    check("R8", "write beats add", stat_rdata, 32'h0000_0003);
    check_reg("R8", 1, 32'h0000_0002);

    // R11: load leaves status, add wins over load on same register
    do_load(6, 32'h1234_5678);
    check("R11", "load keeps status", stat_rdata, 32'h0000_0003);
    check_reg("R11", 6, 32'h1234_5678);
    do_add(6, 1, 1'b0, '0, 1'b1, 32'hAAAA_AAAA);
    @(negedge clk);
    check_reg("R11", 6, 32'h1234_5679);

    // back-to-back adds on the same register
    do_add(2, 10);
    do_add(2, 10);
    do_add(2, -20);
    @(negedge clk);
    check_reg("R1", 2, 32'h0);
    check("R2", "zero after chain", stat_rdata & F_Z, F_Z);

    repeat (3) @(negedge clk);
    check("R10", "scoreboard drained", 32'(sb_q.size()), 32'h0);
    check_all_regs("R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule